// File: doc/BRIEF.md
# Three-Pair PWM Output Polarity and Idle-Level Stage

This block sits between a PWM timebase and the six output pins of a three-phase bridge. For each of three channel pairs it receives two raw activity signals from the counter and deadband logic: one for the side that should switch on first in a period and one for the side that follows. From these it produces a drive value and an output enable for the high-side pin and for the low-side pin of every pair.

Two configuration bits set the idle (inactive) level, one for all high-side pins and one for all low-side pins. The active level of a pin is always the opposite of its idle level. A per-pair orientation bit picks which pin of the pair follows the "first" activity signal. The effective orientation is kept in a shadow register. That register is loaded only on a one-cycle reload strobe. In complementary mode it is loaded only on the deadband-complete strobe that comes after a reload. After reset a short settle counter keeps every pin undriven. After that, only the pairs whose enable bit is set drive their pins. The other pairs stay high-impedance so the pins can be used for other purposes.

Top module: `pwm_pair_outstage`

## Requirements
- R1: When a pair is not running (its run bit is 0, or the settle interval has not finished), its high pin equals `idle_lvl_hi` and its low pin equals `idle_lvl_lo`.
- R2: When a pair is running with orientation 0, the high pin is `first_act ^ idle_lvl_hi` and the low pin is `second_act ^ idle_lvl_lo`. Active level = inverse of idle level.
- R3: When a pair is running with orientation 1, the high pin is `second_act ^ idle_lvl_hi` and the low pin is `first_act ^ idle_lvl_lo`. The idle levels are unchanged by orientation.
- R4: When `comp_mode` is 0, the effective orientation changes only at a clock edge where `reload_pulse` is 1. It then takes the `orient_req` value present at that edge. A changed `orient_req` without a reload has no effect on the pins.
- R5: When `comp_mode` is 1, a reload only captures `orient_req`. The captured value becomes effective at the next edge where `dbdone_pulse` is 1. Changes to `orient_req` after the capture are ignored. A `dbdone_pulse` with no capture pending has no effect.
- R6: While `rst_n` is 0, and until the SETTLE_CYC-th rising edge after its release, all output enables are 0 and every pin holds its idle level. After reset the effective orientation is 0 for all pairs.
- R7: After settling, `oe_hi[i]` and `oe_lo[i]` both equal `pair_en[i]`. A pair with enable 0 never drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_en | input | N_PAIRS | Per-pair drive enable |
| idle_lvl_hi | input | 1 | Idle level of all high-side pins |
| idle_lvl_lo | input | 1 | Idle level of all low-side pins |
| orient_req | input | N_PAIRS | Requested orientation per pair (1 = low side first) |
| comp_mode | input | 1 | Complementary mode: orientation waits for deadband completion |
| reload_pulse | input | 1 | One-cycle reload strobe from the timebase |
| dbdone_pulse | input | 1 | One-cycle deadband-complete strobe |
| run | input | N_PAIRS | Pair is being modulated |
| first_act | input | N_PAIRS | Raw activity of the side that leads in a period |
| second_act | input | N_PAIRS | Raw activity of the side that trails |
| pin_hi | output | N_PAIRS | High-side pin drive value |
| pin_lo | output | N_PAIRS | Low-side pin drive value |
| oe_hi | output | N_PAIRS | High-side output enable |
| oe_lo | output | N_PAIRS | Low-side output enable |

## Verification
The assertions assume that the reload and deadband strobes are clean single-cycle pulses. They also assume that every input is stable around the rising clock edge. Beyond that, the checks on orientation only look at whether a strobe was present. The bench drives all inputs on the falling edge. It raises each strobe for exactly one cycle, and it gives each complementary-mode reload its own deadband strobe a few cycles later. So the stimulus stays inside these assumptions while still trying an orphan deadband strobe and request changes between the two strobes.

// File: rtl/pwmps_pkg.sv
package pwmps_pkg;

  // Which raw activity a pin follows: orientation 0 keeps the natural order.
  function automatic logic pick_side(input logic orient, input logic lead, input logic trail);
    return orient ? trail : lead;
  endfunction

  // Pin value: idle level when not running, otherwise activity flips the idle level.
  function automatic logic pin_level(input logic running, input logic act, input logic idle);
    return running ? (act ^ idle) : idle;
  endfunction

endpackage

// File: rtl/pwmps_settle.sv
module pwmps_settle #(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic settled
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_q != LIMIT)
      cnt_q <= cnt_q + 1'b1;
  end

  assign settled = (cnt_q == LIMIT);
endmodule

// File: rtl/pwmps_orient_shadow.sv
module pwmps_orient_shadow #(
  parameter int unsigned N_PAIRS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               comp_mode,
  input  logic               reload_pulse,
  input  logic               dbdone_pulse,
  input  logic [N_PAIRS-1:0] orient_req,
  output logic [N_PAIRS-1:0] orient_eff
);
  logic [N_PAIRS-1:0] eff_q, held_q;
  logic               pend_q;
  logic               direct_load, deferred_load, capture;

  assign direct_load   = reload_pulse && !comp_mode;
  assign deferred_load = dbdone_pulse && pend_q;
  assign capture       = reload_pulse && comp_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q  <= '0;
      held_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (direct_load)
        eff_q <= orient_req;
      else if (deferred_load)
        eff_q <= held_q;

      if (capture) begin
        held_q <= orient_req;
        pend_q <= 1'b1;
      end else if (deferred_load || !comp_mode) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign orient_eff = eff_q;
endmodule

// File: rtl/pwmps_pair_drive.sv
module pwmps_pair_drive
  import pwmps_pkg::*;
(
  input  logic orient,
  input  logic lead_act,
  input  logic trail_act,
  input  logic run,
  input  logic settled,
  input  logic en,
  input  logic idle_hi,
  input  logic idle_lo,
  output logic pin_hi,
  output logic pin_lo,
  output logic oe_hi,
  output logic oe_lo
);
  logic running, act_hi, act_lo;

  assign running = run && settled;
  assign act_hi  = pick_side(orient, lead_act, trail_act);
  assign act_lo  = pick_side(orient, trail_act, lead_act);

  assign pin_hi = pin_level(running, act_hi, idle_hi);
  assign pin_lo = pin_level(running, act_lo, idle_lo);
  assign oe_hi  = en && settled;
  assign oe_lo  = en && settled;
endmodule

// File: rtl/pwm_pair_outstage.sv
module pwm_pair_outstage #(
  parameter int unsigned N_PAIRS    = 3,
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PAIRS-1:0] pair_en,
  input  logic               idle_lvl_hi,
  input  logic               idle_lvl_lo,
  input  logic [N_PAIRS-1:0] orient_req,
  input  logic               comp_mode,
  input  logic               reload_pulse,
  input  logic               dbdone_pulse,
  input  logic [N_PAIRS-1:0] run,
  input  logic [N_PAIRS-1:0] first_act,
  input  logic [N_PAIRS-1:0] second_act,
  output logic [N_PAIRS-1:0] pin_hi,
  output logic [N_PAIRS-1:0] pin_lo,
  output logic [N_PAIRS-1:0] oe_hi,
  output logic [N_PAIRS-1:0] oe_lo
);
  logic               settled;
  logic [N_PAIRS-1:0] orient_eff;

  pwmps_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .settled (settled)
  );

  pwmps_orient_shadow #(.N_PAIRS(N_PAIRS)) u_shadow (
    .clk          (clk),
    .rst_n        (rst_n),
    .comp_mode    (comp_mode),
    .reload_pulse (reload_pulse),
    .dbdone_pulse (dbdone_pulse),
    .orient_req   (orient_req),
    .orient_eff   (orient_eff)
  );

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    pwmps_pair_drive u_drive (
      .orient    (orient_eff[p]),
      .lead_act  (first_act[p]),
      .trail_act (second_act[p]),
      .run       (run[p]),
      .settled   (settled),
      .en        (pair_en[p]),
      .idle_hi   (idle_lvl_hi),
      .idle_lo   (idle_lvl_lo),
      .pin_hi    (pin_hi[p]),
      .pin_lo    (pin_lo[p]),
      .oe_hi     (oe_hi[p]),
      .oe_lo     (oe_lo[p])
    );
  end
endmodule

// File: rtl/pwm_pair_outstage_chk.sv
module pwm_pair_outstage_chk #(
  parameter int unsigned N_PAIRS = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_PAIRS-1:0] pair_en,
  input logic               idle_lvl_hi,
  input logic               idle_lvl_lo,
  input logic [N_PAIRS-1:0] orient_req,
  input logic               comp_mode,
  input logic               reload_pulse,
  input logic               dbdone_pulse,
  input logic [N_PAIRS-1:0] run,
  input logic [N_PAIRS-1:0] pin_hi,
  input logic [N_PAIRS-1:0] pin_lo,
  input logic [N_PAIRS-1:0] oe_hi,
  input logic [N_PAIRS-1:0] oe_lo,
  input logic [N_PAIRS-1:0] orient_eff,
  input logic               settled
);
  // R6: nothing drives while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R6: assert ((oe_hi | oe_lo) == '0)
        else $error("oe active during reset");
    end
  end

  assert_unsettled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !settled |-> ((oe_hi | oe_lo) == '0));

  assert_enable_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((oe_hi & ~pair_en) == '0) && (oe_hi == oe_lo));

  assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (((pin_hi ^ {N_PAIRS{idle_lvl_hi}}) & ~run) == '0) &&
    (((pin_lo ^ {N_PAIRS{idle_lvl_lo}}) & ~run) == '0));

  assert_reload_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_pulse && !comp_mode) |=> (orient_eff == $past(orient_req)));

  assert_hold_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_pulse && !dbdone_pulse) |=> $stable(orient_eff));

  assert_comp_reload_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_mode && reload_pulse && !dbdone_pulse) |=> $stable(orient_eff));
endmodule

bind pwm_pair_outstage pwm_pair_outstage_chk #(.N_PAIRS(N_PAIRS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pair_en      (pair_en),
  .idle_lvl_hi  (idle_lvl_hi),
  .idle_lvl_lo  (idle_lvl_lo),
  .orient_req   (orient_req),
  .comp_mode    (comp_mode),
  .reload_pulse (reload_pulse),
  .dbdone_pulse (dbdone_pulse),
  .run          (run),
  .pin_hi       (pin_hi),
  .pin_lo       (pin_lo),
  .oe_hi        (oe_hi),
  .oe_lo        (oe_lo),
  .orient_eff   (orient_eff),
  .settled      (settled)
);

// File: tb/pwm_pair_outstage_tb.sv
module pwm_pair_outstage_tb;
  localparam int NP = 3;
  localparam int SC = 4;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] pair_en = '0, orient_req = '0, run = '0, first_act = '0, second_act = '0;
  logic idle_lvl_hi = 0, idle_lvl_lo = 0, comp_mode = 0, reload_pulse = 0, dbdone_pulse = 0;
  logic [NP-1:0] pin_hi, pin_lo, oe_hi, oe_lo;

  always #10 clk = ~clk;

  pwm_pair_outstage #(.N_PAIRS(NP), .SETTLE_CYC(SC)) u_dut (.*);

  typedef struct {
    string tag;
    logic [NP-1:0] hi, lo, oeh, oel;
  } exp_t;
  exp_t sbq[$];

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // bench-side model state
  int m_cnt = 0;
  logic [NP-1:0] m_or = '0, m_held = '0;
  bit m_pend = 0;

  // Driver: inputs already set; advance model across one edge and queue expectation
  task automatic step(input string tag);
    exp_t e;
    logic set_ok;
    if (!rst_n) begin
      m_cnt = 0; m_or = '0; m_pend = 0;
    end else begin
      if (m_cnt < SC) m_cnt++;
      if (!comp_mode) begin
        if (reload_pulse) m_or = orient_req;
        m_pend = 0;
      end else begin
        if (dbdone_pulse && m_pend) begin m_or = m_held; m_pend = 0; end
        if (reload_pulse) begin m_held = orient_req; m_pend = 1; end
      end
    end
    set_ok = rst_n && (m_cnt == SC);
    e.tag = tag;
    for (int i = 0; i < NP; i++) begin
      logic go, ah, al;
      go = set_ok && run[i];
      ah = m_or[i] ? second_act[i] : first_act[i];
      al = m_or[i] ? first_act[i] : second_act[i];
      e.hi[i]  = go ? ~(ah ~^ idle_lvl_hi) : idle_lvl_hi;
      e.lo[i]  = go ? ~(al ~^ idle_lvl_lo) : idle_lvl_lo;
      e.oeh[i] = set_ok && pair_en[i];
      e.oel[i] = set_ok && pair_en[i];
    end
    sbq.push_back(e);
    @(negedge clk);
    reload_pulse = 0;
    dbdone_pulse = 0;
  endtask

  // Monitor: compare shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        n_tests++;
        if (pin_hi !== e.hi || pin_lo !== e.lo || oe_hi !== e.oeh || oe_lo !== e.oel) begin
          n_fail++;
          $display("FAIL %s: got hi=%b lo=%b oeh=%b oel=%b exp hi=%b lo=%b oeh=%b oel=%b",
                   e.tag, pin_hi, pin_lo, oe_hi, oe_lo, e.hi, e.lo, e.oeh, e.oel);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle_lvl_hi = 1; idle_lvl_lo = 0; pair_en = 3'b101; run = 3'b111;
    first_act = 3'b111; second_act = 3'b000;
    step("R6 reset held quiet");
    step("R6 reset held idle pins");
    rst_n = 1;
    step("R6 settle 1");
    step("R6 settle 2");
    step("R1 settle 3 idle pins");
    step("R7 settled enables");
    // orientation 0 patterns
    first_act = 3'b101; second_act = 3'b010;
    step("R2 orient0 pattern a");
    first_act = 3'b000; second_act = 3'b111;
    step("R2 orient0 pattern b");
    // request without reload: ignored
    orient_req = 3'b110;
    step("R4 request without reload ignored");
    step("R4 still ignored");
    reload_pulse = 1;
    step("R4 reload applies orientation");
    first_act = 3'b011; second_act = 3'b100;
    step("R3 orient110 swap");
    // pair not running
    run = 3'b010;
    step("R1 stopped pairs idle");
    run = 3'b111;
    // flipped idle levels
    idle_lvl_hi = 0; idle_lvl_lo = 1;
    step("R2 flipped idle levels");
    // complementary mode
    comp_mode = 1; orient_req = 3'b011;
    reload_pulse = 1;
    step("R5 comp reload does not apply");
    orient_req = 3'b000;
    step("R5 later request ignored");
    step("R5 waiting deadband");
    dbdone_pulse = 1;
    step("R5 deadband applies captured");
    dbdone_pulse = 1;
    step("R5 orphan deadband no effect");
    orient_req = 3'b111; reload_pulse = 1; dbdone_pulse = 1;
    step("R5 reload with deadband same edge");
    first_act = 3'b110;
    step("R5 still pending");
    dbdone_pulse = 1;
    step("R5 applies 111");
    // enables
    pair_en = 3'b010;
    step("R7 enable change");
    pair_en = 3'b000;
    step("R7 all disabled");
    // reset again mid-run
    rst_n = 0;
    step("R6 reset returns orientation 0");
    rst_n = 1; comp_mode = 0; pair_en = 3'b111;
    step("R6 re-settle 1");
    step("R6 re-settle 2");
    step("R6 re-settle 3");
    step("R6 orient reset to 0 after settle");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule